// File: doc/BRIEF.md
# Five-Tuple Service Classifier with Weighted Slot Scheduler

This block has two independent paths. The classification path takes one header descriptor per cycle: source and destination address, source and destination port, and protocol. It returns a service class tag one cycle later. Three tiers exist. The top tier covers traffic to or from one configured host, and name-lookup traffic on port 53 over TCP or UDP. The middle tier covers traffic whose source or destination falls inside one of a small set of configured site prefixes. The bottom tier covers traffic sourced from a configured wireless prefix, and it also takes every header that no rule matches. Rules are evaluated strictly top tier first. A separate configuration write port loads the host address and the prefixes.

The scheduling path is driven by an output slot strobe and by one backlog flag per class queue. It walks a fixed ten-position wheel: five top-class positions, then three middle-class positions, then two bottom-class positions. On each slot it grants the owner of the current position when that class has work. Otherwise the slot goes to the highest-priority class that has work. With every queue busy, service is split 50/30/20. Packet storage stays outside the block.

Top module: `svc_class_sched`

## Requirements
- R1: While reset is held and on the first cycle after it, `cls_valid` and `grant_valid` are 0.
- R2: A header presented with `hdr_valid` high gives `cls_valid` high on the next cycle. A cycle without `hdr_valid` gives `cls_valid` low on the next cycle.
- R3: A write with `cfg_kind`=0 stores the host address. A header whose source or destination equals that host is tagged class 0 (top), with `cls_miss`=0.
- R4: A header with source or destination port 53 and protocol 6 or 17 is tagged class 0. Port 53 with any other protocol does not match this rule.
- R5: A write with `cfg_kind`=1 loads site prefix slot `cfg_idx` (base `cfg_addr`, length `cfg_plen` leading bits) and enables it. A header whose source or destination lies in an enabled site prefix is tagged class 1 (middle). Unloaded slots never match.
- R6: A write with `cfg_kind`=2 loads the wireless prefix. A header whose source lies in it is tagged class 2 (bottom) with `cls_miss`=0. A header whose destination alone lies in it does not match this rule.
- R7: A header matching no rule is tagged class 2 with `cls_miss`=1.
- R8: When several rules match, the top-class rules win over the site rule, and the site rule wins over the wireless rule.
- R9: After reset the wheel starts at position 0. Positions 0-4 belong to class 0, 5-7 to class 1 and 8-9 to class 2. The wheel moves one position per slot. With all three backlog flags (`q_ne` bit k for class k) set, 100 slots grant exactly 50, 30 and 20.
- R10: When the owner of a slot has no backlog, the slot goes to the lowest-numbered class with backlog. With no backlog at all, `grant_valid` stays 0 for that slot.
- R11: The grant appears on the cycle after `slot_en`. Cycles without `slot_en` give `grant_valid`=0 and do not move the wheel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | 0 host, 1 site prefix, 2 wireless prefix |
| cfg_idx | input | 2 | Site prefix slot index |
| cfg_addr | input | 32 | Address or prefix base |
| cfg_plen | input | 6 | Prefix length in leading bits |
| hdr_valid | input | 1 | Header descriptor valid |
| hdr_src | input | 32 | Source address |
| hdr_dst | input | 32 | Destination address |
| hdr_sport | input | 16 | Source port |
| hdr_dport | input | 16 | Destination port |
| hdr_proto | input | 8 | Protocol number |
| cls_valid | output | 1 | Class result valid |
| cls_tag | output | 2 | Class: 0 top, 1 middle, 2 bottom |
| cls_miss | output | 1 | No rule matched |
| slot_en | input | 1 | Output slot available |
| q_ne | input | 3 | Per-class backlog flags |
| grant_valid | output | 1 | A class was granted the slot |
| grant_cls | output | 2 | Granted class |

## Verification
The scheduler assertions assume that `q_ne` is stable across the slot it describes. They also assume that its bits mean what the requirements say. Their inferences are therefore drawn only from the flags seen on the same edge as `slot_en`. The classifier assertions assume that configuration writes do not land on the same cycle as a header they would change. The bench keeps all writes in a setup phase before any header is sent, and it changes `q_ne` only on the falling edge together with `slot_en`.

// File: rtl/svc_pkg.sv
// Package: shared class codes and configuration kinds for the
// classifier/scheduler block. Assumes class code order equals priority.
package svc_pkg;
    typedef enum logic [1:0] {
        CLS_TOP = 2'd0,
        CLS_MID = 2'd1,
        CLS_LOW = 2'd2
    } svc_cls_e;

    localparam logic [1:0] CFG_HOST = 2'd0;
    localparam logic [1:0] CFG_SITE = 2'd1;
    localparam logic [1:0] CFG_WIFI = 2'd2;
endpackage

// File: rtl/prefix_match.sv
// prefix_match: combinational test of whether an address falls inside
// a base/length prefix. Assumes length counts leading bits; a length of
// zero matches everything and lengths above ADDR_W act as full width.
module prefix_match #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 6
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  logic [LEN_W-1:0]  plen,
    output logic              hit
);
    logic [ADDR_W-1:0] mask;

    // builds the leading-ones mask and compares under it
    always_comb begin
        mask = ~({ADDR_W{1'b1}} >> plen);
        hit  = ((addr ^ base) & mask) == '0;
    end
endmodule

// File: rtl/hdr_classifier.sv
// hdr_classifier: holds the rule configuration and tags each header with
// a service class one cycle after it arrives. Assumes configuration writes
// are not issued on the same cycle as headers they should affect.
module hdr_classifier
    import svc_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int PORT_W    = 16,
    parameter int N_SITE    = 4,
    parameter int DNS_PORT  = 53,
    parameter int PROTO_TCP = 6,
    parameter int PROTO_UDP = 17,
    localparam int LEN_W    = $clog2(ADDR_W + 1),
    localparam int IDX_W    = (N_SITE > 1) ? $clog2(N_SITE) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_kind,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [LEN_W-1:0]  cfg_plen,
    input  logic              hdr_valid,
    input  logic [ADDR_W-1:0] hdr_src,
    input  logic [ADDR_W-1:0] hdr_dst,
    input  logic [PORT_W-1:0] hdr_sport,
    input  logic [PORT_W-1:0] hdr_dport,
    input  logic [7:0]        hdr_proto,
    output logic              cls_valid,
    output logic [1:0]        cls_tag,
    output logic              cls_miss
);
    logic [ADDR_W-1:0] host_addr;
    logic              host_vld;
    logic [ADDR_W-1:0] site_base [N_SITE];
    logic [LEN_W-1:0]  site_len  [N_SITE];
    logic [N_SITE-1:0] site_vld;
    logic [ADDR_W-1:0] wifi_base;
    logic [LEN_W-1:0]  wifi_len;
    logic              wifi_vld;

    logic [N_SITE-1:0] site_src_hit, site_dst_hit;
    logic              wifi_src_hit;
    logic              top_hit, mid_hit, low_hit, dns_proto;

    // stores host, site and wireless rules from the configuration port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_addr <= '0;
            host_vld  <= 1'b0;
            site_vld  <= '0;
            wifi_base <= '0;
            wifi_len  <= '0;
            wifi_vld  <= 1'b0;
            for (int i = 0; i < N_SITE; i++) begin
                site_base[i] <= '0;
                site_len[i]  <= '0;
            end
        end else if (cfg_we) begin
            case (cfg_kind)
                CFG_HOST: begin
                    host_addr <= cfg_addr;
                    host_vld  <= 1'b1;
                end
                CFG_SITE: begin
                    if (int'(cfg_idx) < N_SITE) begin
                        site_base[cfg_idx] <= cfg_addr;
                        site_len[cfg_idx]  <= cfg_plen;
                        site_vld[cfg_idx]  <= 1'b1;
                    end
                end
                CFG_WIFI: begin
                    wifi_base <= cfg_addr;
                    wifi_len  <= cfg_plen;
                    wifi_vld  <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // one source and one destination comparator per site prefix
    for (genvar g = 0; g < N_SITE; g++) begin : g_site
        prefix_match #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_src (
            .addr(hdr_src), .base(site_base[g]), .plen(site_len[g]),
            .hit(site_src_hit[g]));
        prefix_match #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_dst (
            .addr(hdr_dst), .base(site_base[g]), .plen(site_len[g]),
            .hit(site_dst_hit[g]));
    end

    prefix_match #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_wifi (
        .addr(hdr_src), .base(wifi_base), .plen(wifi_len),
        .hit(wifi_src_hit));

    // evaluates the three rule groups for the current header
    always_comb begin
        dns_proto = (hdr_proto == 8'(PROTO_TCP)) || (hdr_proto == 8'(PROTO_UDP));
        top_hit   = (host_vld && (hdr_src == host_addr || hdr_dst == host_addr))
                 || (dns_proto && (hdr_sport == PORT_W'(DNS_PORT)
                                || hdr_dport == PORT_W'(DNS_PORT)));
        mid_hit   = |((site_src_hit | site_dst_hit) & site_vld);
        low_hit   = wifi_vld && wifi_src_hit;
    end

    // registers the class decision, top rules first
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cls_valid <= 1'b0;
            cls_tag   <= CLS_LOW;
            cls_miss  <= 1'b0;
        end else begin
            cls_valid <= hdr_valid;
            if (hdr_valid) begin
                cls_miss <= 1'b0;
                if (top_hit)      cls_tag <= CLS_TOP;
                else if (mid_hit) cls_tag <= CLS_MID;
                else begin
                    cls_tag  <= CLS_LOW;
                    cls_miss <= !low_hit;
                end
            end
        end
    end

    // R2
    cls_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |=> cls_valid);
    // R2
    cls_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hdr_valid |=> !cls_valid);
    // R7
    miss_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cls_valid && cls_miss) |-> cls_tag == CLS_LOW);
    // R8
    top_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && top_hit) |=> (cls_tag == CLS_TOP && !cls_miss));
endmodule

// File: rtl/slot_wheel.sv
// slot_wheel: weighted slot scheduler over three class queues. A wheel of
// W_TOP+W_MID+W_LOW positions names an owner per slot; an idle owner yields
// to the lowest-numbered class with backlog. Assumes q_ne is valid with
// slot_en and bit k belongs to class k.
module slot_wheel
    import svc_pkg::*;
#(
    parameter int W_TOP = 5,
    parameter int W_MID = 3,
    parameter int W_LOW = 2,
    localparam int WHEEL = W_TOP + W_MID + W_LOW,
    localparam int PTR_W = (WHEEL > 1) ? $clog2(WHEEL) : 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       slot_en,
    input  logic [2:0] q_ne,
    output logic       grant_valid,
    output logic [1:0] grant_cls
);
    logic [PTR_W-1:0] ptr;
    logic [1:0]       owner, pick;
    logic             owner_busy, any_busy;

    // maps the wheel position to its owner and resolves the pick
    always_comb begin
        if (int'(ptr) < W_TOP)              owner = CLS_TOP;
        else if (int'(ptr) < W_TOP + W_MID) owner = CLS_MID;
        else                                owner = CLS_LOW;
        case (owner)
            CLS_TOP: owner_busy = q_ne[0];
            CLS_MID: owner_busy = q_ne[1];
            default: owner_busy = q_ne[2];
        endcase
        any_busy = |q_ne;
        if (owner_busy)   pick = owner;
        else if (q_ne[0]) pick = CLS_TOP;
        else if (q_ne[1]) pick = CLS_MID;
        else              pick = CLS_LOW;
    end

    // advances the wheel and registers the grant per slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr         <= '0;
            grant_valid <= 1'b0;
            grant_cls   <= CLS_TOP;
        end else begin
            grant_valid <= 1'b0;
            if (slot_en) begin
                ptr         <= (int'(ptr) == WHEEL - 1) ? '0 : ptr + 1'b1;
                grant_valid <= any_busy;
                grant_cls   <= pick;
            end
        end
    end

    // R9
    ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(ptr) < WHEEL);
    // R10
    idle_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_en && q_ne == 3'b000) |=> !grant_valid);
    // R10
    only_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_en && q_ne == 3'b100) |=> (grant_valid && grant_cls == CLS_LOW));
    // R11
    no_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_en |=> !grant_valid);
    // R11
    hold_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_en |=> $stable(ptr));
endmodule

// File: rtl/svc_class_sched.sv
// svc_class_sched: top of the five-tuple classifier and weighted slot
// scheduler. The two paths share only clock and reset; the caller moves
// tagged packets into the class queues and reports their backlog.
module svc_class_sched #(
    parameter int ADDR_W   = 32,
    parameter int PORT_W   = 16,
    parameter int N_SITE   = 4,
    parameter int DNS_PORT = 53,
    parameter int W_TOP    = 5,
    parameter int W_MID    = 3,
    parameter int W_LOW    = 2,
    localparam int LEN_W   = $clog2(ADDR_W + 1),
    localparam int IDX_W   = (N_SITE > 1) ? $clog2(N_SITE) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_kind,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [LEN_W-1:0]  cfg_plen,
    input  logic              hdr_valid,
    input  logic [ADDR_W-1:0] hdr_src,
    input  logic [ADDR_W-1:0] hdr_dst,
    input  logic [PORT_W-1:0] hdr_sport,
    input  logic [PORT_W-1:0] hdr_dport,
    input  logic [7:0]        hdr_proto,
    output logic              cls_valid,
    output logic [1:0]        cls_tag,
    output logic              cls_miss,
    input  logic              slot_en,
    input  logic [2:0]        q_ne,
    output logic              grant_valid,
    output logic [1:0]        grant_cls
);
    hdr_classifier #(
        .ADDR_W(ADDR_W), .PORT_W(PORT_W), .N_SITE(N_SITE), .DNS_PORT(DNS_PORT)
    ) u_cls (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_idx(cfg_idx),
        .cfg_addr(cfg_addr), .cfg_plen(cfg_plen),
        .hdr_valid(hdr_valid), .hdr_src(hdr_src), .hdr_dst(hdr_dst),
        .hdr_sport(hdr_sport), .hdr_dport(hdr_dport), .hdr_proto(hdr_proto),
        .cls_valid(cls_valid), .cls_tag(cls_tag), .cls_miss(cls_miss)
    );

    slot_wheel #(.W_TOP(W_TOP), .W_MID(W_MID), .W_LOW(W_LOW)) u_sched (
        .clk(clk), .rst_n(rst_n), .slot_en(slot_en), .q_ne(q_ne),
        .grant_valid(grant_valid), .grant_cls(grant_cls)
    );
endmodule

// File: tb/sim_svc_class_sched.sv
module sim_svc_class_sched;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_kind = '0;
    logic [1:0]  cfg_idx = '0;
    logic [31:0] cfg_addr = '0;
    logic [5:0]  cfg_plen = '0;
    logic        hdr_valid = 1'b0;
    logic [31:0] hdr_src = '0, hdr_dst = '0;
    logic [15:0] hdr_sport = '0, hdr_dport = '0;
    logic [7:0]  hdr_proto = '0;
    logic        cls_valid, cls_miss;
    logic [1:0]  cls_tag;
    logic        slot_en = 1'b0;
    logic [2:0]  q_ne = '0;
    logic        grant_valid;
    logic [1:0]  grant_cls;

    int total = 0;
    int bad = 0;
    bit done = 0;

    localparam logic [31:0] HOST  = 32'h0A000005;
    localparam logic [31:0] OTHER = 32'h08080808;
    localparam logic [31:0] FAR   = 32'h01020304;

    always #2 clk = ~clk;

    svc_class_sched u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
        .cfg_idx(cfg_idx), .cfg_addr(cfg_addr), .cfg_plen(cfg_plen),
        .hdr_valid(hdr_valid), .hdr_src(hdr_src), .hdr_dst(hdr_dst),
        .hdr_sport(hdr_sport), .hdr_dport(hdr_dport), .hdr_proto(hdr_proto),
        .cls_valid(cls_valid), .cls_tag(cls_tag), .cls_miss(cls_miss),
        .slot_en(slot_en), .q_ne(q_ne),
        .grant_valid(grant_valid), .grant_cls(grant_cls)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] k, input logic [1:0] i,
                             input logic [31:0] a, input logic [5:0] l);
        cfg_we = 1'b1; cfg_kind = k; cfg_idx = i; cfg_addr = a; cfg_plen = l;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // sends one header and checks tag and miss one cycle later, then idle
    task automatic classify(input string req, input logic [31:0] s,
                            input logic [31:0] d, input logic [15:0] sp,
                            input logic [15:0] dp, input logic [7:0] pr,
                            input int exp_tag, input int exp_miss);
        hdr_valid = 1'b1; hdr_src = s; hdr_dst = d;
        hdr_sport = sp; hdr_dport = dp; hdr_proto = pr;
        @(posedge clk); #1;
        check({req, " valid"}, int'(cls_valid), 1);
        check({req, " tag"}, int'(cls_tag), exp_tag);
        check({req, " miss"}, int'(cls_miss), exp_miss);
        @(negedge clk);
        hdr_valid = 1'b0;
    endtask

    task automatic slot(input logic [2:0] ne, output int gv, output int gc);
        slot_en = 1'b1; q_ne = ne;
        @(posedge clk); #1;
        gv = int'(grant_valid); gc = int'(grant_cls);
        @(negedge clk);
        slot_en = 1'b0;
    endtask

    task automatic t_reset();
        // R1: outputs low under reset and on the first cycle after
        check("R1 cls_valid in reset", int'(cls_valid), 0);
        check("R1 grant_valid in reset", int'(grant_valid), 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 cls_valid after reset", int'(cls_valid), 0);
        check("R1 grant_valid after reset", int'(grant_valid), 0);
        @(negedge clk);
    endtask

    task automatic t_setup();
        cfg_write(2'd0, 2'd0, HOST, 6'd0);
        cfg_write(2'd1, 2'd0, 32'hAC100000, 6'd12);
        cfg_write(2'd1, 2'd2, 32'hC0A80100, 6'd24);
        cfg_write(2'd2, 2'd0, 32'h0A800000, 6'd9);
    endtask

    task automatic t_classify();
        classify("R3 src host", HOST, FAR, 16'd1000, 16'd2000, 8'd6, 0, 0);
        classify("R3 dst host", OTHER, HOST, 16'd1000, 16'd2000, 8'd6, 0, 0);
        classify("R4 sport udp", OTHER, FAR, 16'd53, 16'd2000, 8'd17, 0, 0);
        classify("R4 dport tcp", OTHER, FAR, 16'd1000, 16'd53, 8'd6, 0, 0);
        classify("R4 other proto", OTHER, FAR, 16'd1000, 16'd53, 8'd1, 2, 1);
        classify("R5 src site", 32'hAC1F0001, FAR, 16'd1, 16'd2, 8'd6, 1, 0);
        classify("R5 dst site", OTHER, 32'hC0A80177, 16'd1, 16'd2, 8'd6, 1, 0);
        classify("R5 outside prefix", OTHER, 32'hC0A80277, 16'd1, 16'd2, 8'd6, 2, 1);
        classify("R6 wifi src", 32'h0AC80001, FAR, 16'd1, 16'd2, 8'd17, 2, 0);
        classify("R6 wifi dst only", OTHER, 32'h0AC80001, 16'd1, 16'd2, 8'd17, 2, 1);
        classify("R7 no match", OTHER, FAR, 16'd1, 16'd2, 8'd6, 2, 1);
        classify("R8 host over site", HOST, 32'hAC100009, 16'd1, 16'd2, 8'd6, 0, 0);
        classify("R8 site over wifi", 32'h0AC80001, 32'hAC100009, 16'd1, 16'd2, 8'd6, 1, 0);
        classify("R8 dns over wifi", 32'h0AC80001, FAR, 16'd53, 16'd2, 8'd17, 0, 0);
        // R2: one idle cycle drops cls_valid
        @(posedge clk); #1;
        check("R2 cls_valid idle", int'(cls_valid), 0);
        @(negedge clk);
    endtask

    task automatic t_hold();
        int gv, gc;
        int exp_seq[6] = '{0, 0, 0, 0, 0, 1};
        for (int i = 0; i < 3; i++) begin
            slot(3'b111, gv, gc);
            check("R11 grant before pause", gc, exp_seq[i]);
        end
        for (int i = 0; i < 5; i++) begin
            @(posedge clk); #1;
            check("R11 no grant without slot", int'(grant_valid), 0);
            @(negedge clk);
        end
        for (int i = 3; i < 6; i++) begin
            slot(3'b111, gv, gc);
            check("R11 grant after pause", gc, exp_seq[i]);
        end
    endtask

    task automatic count_slots(input string req, input logic [2:0] ne,
                               input int n, input int e0, input int e1,
                               input int e2, input int enone);
        int c[3] = '{0, 0, 0};
        int none = 0;
        int gv, gc;
        for (int i = 0; i < n; i++) begin
            slot(ne, gv, gc);
            if (gv == 0) none++;
            else if (gc < 3) c[gc]++;
        end
        check({req, " class0"}, c[0], e0);
        check({req, " class1"}, c[1], e1);
        check({req, " class2"}, c[2], e2);
        check({req, " idle"}, none, enone);
    endtask

    task automatic t_sched();
        count_slots("R9 all busy", 3'b111, 100, 50, 30, 20, 0);
        count_slots("R10 top idle", 3'b110, 10, 0, 8, 2, 0);
        count_slots("R10 mid idle", 3'b101, 10, 8, 0, 2, 0);
        count_slots("R10 only low", 3'b100, 10, 0, 0, 10, 0);
        count_slots("R10 only top", 3'b001, 10, 10, 0, 0, 0);
        count_slots("R10 none", 3'b000, 10, 0, 0, 0, 10);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_setup();
        t_hold();
        t_classify();
        t_sched();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule